// File: doc/BRIEF.md
# Set-Indexed Translation Cache with Access Checking

This block holds recently used page-table entries so that a virtual page number can be turned into a physical frame number without going to memory. The page number is divided into a set index (low bits) and a tag (high bits). Each set holds several ways. A lookup that finds a matching valid way checks the access rights of the entry and either returns the physical address or reports a fault with a cause code.

A lookup that finds nothing stops the block, and the block asks an external table walker for the entry. The walker answers with a one-cycle fill. The block installs the entry and then replays the held request to produce the response. Two maintenance inputs keep the cache consistent with the page tables. A task-switch flush drops every entry that is not marked global. A single-address invalidate drops the matching entry whether or not it is global, which is what a software shootdown handler needs on each core.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, `reqReady` is 1, and `walkReq` and `rspValid` are 0.
- R2: Set index is `reqVpn[3:0]` and tag is `reqVpn[19:4]`. A request accepted on a clock edge that hits a valid entry with the same tag in that set gives `rspValid` high for one cycle after that edge, with `rspPaddr = {pfn, reqOff}` and `rspCause = 0` when no fault applies.
- R3: On a miss, `walkReq` rises one cycle after acceptance and holds `walkVpn` equal to the request's page number until `fillValid`. The entry is installed on the fill edge, and the response follows one cycle after that. A hit never raises `walkReq`.
- R4: An entry whose present bit is 0 faults on reads and on writes with cause 1 and `rspPaddr = 0`.
- R5: A user-mode access (`reqUser = 1`) to an entry whose user bit is 0 faults with cause 3 and `rspPaddr = 0`.
- R6: A write (`reqWrite = 1`) to an entry whose writable bit is 0 faults with cause 2. When more than one fault applies, the order is: absent first, then user, then write.
- R7: A one-cycle `flushTask` pulse invalidates every entry whose global bit is 0 and keeps global entries. A kept entry then hits without a walk.
- R8: A one-cycle `invValid` pulse invalidates the entry that matches `invVpn` (same set and tag), global or not.
- R9: A fill goes to the lowest-numbered invalid way of the set. When the set is full, it goes to the way named by that set's round-robin pointer, which starts at 0 and advances by one each time it is used.
- R10: While a walk is pending, `reqReady` is 0 and requests are ignored. Each accepted request gets exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request strobe |
| reqReady | output | 1 | Block can accept a request |
| reqVpn | input | 20 | Virtual page number |
| reqOff | input | 12 | Page offset |
| reqWrite | input | 1 | Access is a write |
| reqUser | input | 1 | Access is from user mode |
| rspValid | output | 1 | Response strobe |
| rspPaddr | output | 32 | Physical address, 0 on a fault |
| rspCause | output | 2 | 0 none, 1 absent, 2 write denied, 3 user denied |
| walkReq | output | 1 | Table walk wanted |
| walkVpn | output | 20 | Page number to walk |
| fillValid | input | 1 | Walker returns an entry |
| fillPfn | input | 20 | Frame number of the entry |
| fillPresent | input | 1 | Present bit |
| fillWritable | input | 1 | Writable bit |
| fillUser | input | 1 | User-access bit |
| fillGlobal | input | 1 | Global bit |
| flushTask | input | 1 | Drop all non-global entries |
| invValid | input | 1 | Invalidate one address |
| invVpn | input | 20 | Page number to invalidate |

## Verification
Directed patterns come first. One pass fills a single set past its capacity, which separates filling free ways first from round-robin eviction. Single pages each carry one bad permission, which separates the three fault causes and shows how they rank. A global page and a non-global page share a set across a flush, which shows which entries the flush keeps, and a later invalidate shows that global entries can still be removed. After that, random traffic draws from a small pool of tags on four sets. The pool is larger than the ways, so hits, misses, evictions, flushes and invalidates interleave. During every walk a stray request is driven, which shows that requests are refused while a walk is pending.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ABSENT = 2'd1,
    CAUSE_WRITE  = 2'd2,
    CAUSE_USER   = 2'd3
  } fault_e;

  typedef struct packed {
    logic global;
    logic user;
    logic writable;
    logic present;
  } pteFlags_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic rspLoad;
    logic doFill;
  } ctrlStrobe_t;

endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        lookupHit,
  input  logic        fillValid,
  output logic        reqReady,
  output logic        walkReq,
  output logic        lookupHeld,
  output ctrlStrobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_REPLAY} state_e;

  state_e stateQ, stateNext;

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateNext;
  end

  assign reqReady   = (stateQ == ST_IDLE);
  assign walkReq    = (stateQ == ST_WALK);
  assign lookupHeld = (stateQ == ST_REPLAY);

  always_comb begin
    stateNext = stateQ;
    strobe    = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          if (lookupHit) begin
            strobe.rspLoad = 1'b1;
          end else begin
            strobe.capture = 1'b1;
            stateNext      = ST_WALK;
          end
        end
      end
      ST_WALK: begin
        if (fillValid) begin
          strobe.doFill = 1'b1;
          stateNext     = ST_REPLAY;
        end
      end
      ST_REPLAY: begin
        if (lookupHit) begin
          strobe.rspLoad = 1'b1;
          stateNext      = ST_IDLE;
        end else begin
          stateNext = ST_WALK;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int IDX_W = 4,
  parameter int WAYS  = 4,
  parameter int OFF_W = 12,
  parameter int PFN_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VPN_W-1:0]   reqVpn,
  input  logic [OFF_W-1:0]   reqOff,
  input  logic               reqWrite,
  input  logic               reqUser,
  input  logic               fillValid,
  input  logic [PFN_W-1:0]   fillPfn,
  input  logic               fillPresent,
  input  logic               fillWritable,
  input  logic               fillUser,
  input  logic               fillGlobal,
  input  logic               flushTask,
  input  logic               invValid,
  input  logic [VPN_W-1:0]   invVpn,
  input  ctrlStrobe_t        strobe,
  input  logic               lookupHeld,
  output logic               lookupHit,
  output logic [VPN_W-1:0]   walkVpn,
  output logic               rspValid,
  output logic [PFN_W+OFF_W-1:0] rspPaddr,
  output logic [1:0]         rspCause
);

  localparam int SETS  = 2 ** IDX_W;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int FL_W  = $bits(pteFlags_t);

  // storage
  logic [WAYS-1:0]  validQ [SETS];
  logic [TAG_W-1:0] tagQ   [SETS][WAYS];
  logic [PFN_W-1:0] pfnQ   [SETS][WAYS];
  pteFlags_t        flagQ  [SETS][WAYS];
  logic [WAY_W-1:0] rrQ    [SETS];

  // held request for walk and replay
  logic [VPN_W-1:0] heldVpn;
  logic [OFF_W-1:0] heldOff;
  logic             heldWrite, heldUser;

  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      heldVpn   <= reqVpn;
      heldOff   <= reqOff;
      heldWrite <= reqWrite;
      heldUser  <= reqUser;
    end
  end

  assign walkVpn = heldVpn;

  // lookup
  logic [VPN_W-1:0] lkVpn;
  logic [OFF_W-1:0] lkOff;
  logic             lkWrite, lkUser;
  logic [IDX_W-1:0] lkSet;
  logic [TAG_W-1:0] lkTag;
  logic [WAYS-1:0]  wayHit;

  assign lkVpn   = lookupHeld ? heldVpn   : reqVpn;
  assign lkOff   = lookupHeld ? heldOff   : reqOff;
  assign lkWrite = lookupHeld ? heldWrite : reqWrite;
  assign lkUser  = lookupHeld ? heldUser  : reqUser;
  assign lkSet   = lkVpn[IDX_W-1:0];
  assign lkTag   = lkVpn[VPN_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wayHit[w] = validQ[lkSet][w] && (tagQ[lkSet][w] == lkTag);
  end

  logic [PFN_W-1:0] hitPfn;
  logic [FL_W-1:0]  hitBits;
  pteFlags_t        hitFlags;
  fault_e           cause;

  always_comb begin
    hitPfn  = '0;
    hitBits = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (wayHit[w]) begin
        hitPfn  = hitPfn | pfnQ[lkSet][w];
        hitBits = hitBits | flagQ[lkSet][w];
      end
    end
  end

  assign hitFlags  = pteFlags_t'(hitBits);
  assign lookupHit = |wayHit;

  always_comb begin
    if (!hitFlags.present)                 cause = CAUSE_ABSENT;
    else if (lkUser && !hitFlags.user)     cause = CAUSE_USER;
    else if (lkWrite && !hitFlags.writable) cause = CAUSE_WRITE;
    else                                   cause = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspCause <= CAUSE_NONE;
      rspPaddr <= '0;
    end else begin
      rspValid <= strobe.rspLoad;
      rspCause <= strobe.rspLoad ? cause : CAUSE_NONE;
      rspPaddr <= (strobe.rspLoad && cause == CAUSE_NONE) ? {hitPfn, lkOff} : '0;
    end
  end

  // victim choice for the held set
  logic [IDX_W-1:0] heldSet;
  logic [TAG_W-1:0] heldTag;
  logic [WAY_W-1:0] victim;
  logic             foundFree;

  assign heldSet = heldVpn[IDX_W-1:0];
  assign heldTag = heldVpn[VPN_W-1:IDX_W];

  always_comb begin
    victim    = rrQ[heldSet];
    foundFree = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!validQ[heldSet][w]) begin
        victim    = WAY_W'(w);
        foundFree = 1'b1;
      end
    end
  end

  logic [IDX_W-1:0] invSet;
  logic [TAG_W-1:0] invTag;
  assign invSet = invVpn[IDX_W-1:0];
  assign invTag = invVpn[VPN_W-1:IDX_W];

  // valid bits and round-robin pointers; a fill overrides a clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        rrQ[s]    <= '0;
      end
    end else begin
      if (flushTask) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            if (!flagQ[s][w].global) validQ[s][w] <= 1'b0;
      end
      if (invValid) begin
        for (int w = 0; w < WAYS; w++)
          if (tagQ[invSet][w] == invTag) validQ[invSet][w] <= 1'b0;
      end
      if (strobe.doFill) begin
        validQ[heldSet][victim] <= 1'b1;
        if (!foundFree) rrQ[heldSet] <= rrQ[heldSet] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.doFill && fillValid) begin
      tagQ[heldSet][victim]  <= heldTag;
      pfnQ[heldSet][victim]  <= fillPfn;
      flagQ[heldSet][victim] <= '{global: fillGlobal, user: fillUser,
                                  writable: fillWritable, present: fillPresent};
    end
  end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int IDX_W = 4,
  parameter int WAYS  = 4,
  parameter int OFF_W = 12,
  parameter int PFN_W = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [VPN_W-1:0]       reqVpn,
  input  logic [OFF_W-1:0]       reqOff,
  input  logic                   reqWrite,
  input  logic                   reqUser,
  output logic                   rspValid,
  output logic [PFN_W+OFF_W-1:0] rspPaddr,
  output logic [1:0]             rspCause,
  output logic                   walkReq,
  output logic [VPN_W-1:0]       walkVpn,
  input  logic                   fillValid,
  input  logic [PFN_W-1:0]       fillPfn,
  input  logic                   fillPresent,
  input  logic                   fillWritable,
  input  logic                   fillUser,
  input  logic                   fillGlobal,
  input  logic                   flushTask,
  input  logic                   invValid,
  input  logic [VPN_W-1:0]       invVpn
);

  ctrlStrobe_t strobe;
  logic        lookupHit;
  logic        lookupHeld;

  xlat_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .lookupHit  (lookupHit),
    .fillValid  (fillValid),
    .reqReady   (reqReady),
    .walkReq    (walkReq),
    .lookupHeld (lookupHeld),
    .strobe     (strobe)
  );

  xlat_datapath #(
    .VPN_W(VPN_W), .IDX_W(IDX_W), .WAYS(WAYS), .OFF_W(OFF_W), .PFN_W(PFN_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .reqVpn       (reqVpn),
    .reqOff       (reqOff),
    .reqWrite     (reqWrite),
    .reqUser      (reqUser),
    .fillValid    (fillValid),
    .fillPfn      (fillPfn),
    .fillPresent  (fillPresent),
    .fillWritable (fillWritable),
    .fillUser     (fillUser),
    .fillGlobal   (fillGlobal),
    .flushTask    (flushTask),
    .invValid     (invValid),
    .invVpn       (invVpn),
    .strobe       (strobe),
    .lookupHeld   (lookupHeld),
    .lookupHit    (lookupHit),
    .walkVpn      (walkVpn),
    .rspValid     (rspValid),
    .rspPaddr     (rspPaddr),
    .rspCause     (rspCause)
  );

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VPN_W = 20,
  parameter int PA_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reqReady,
  input logic             rspValid,
  input logic [PA_W-1:0]  rspPaddr,
  input logic [1:0]       rspCause,
  input logic             walkReq,
  input logic [VPN_W-1:0] walkVpn,
  input logic             fillValid
);

  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (walkReq && !fillValid) |=> (walkReq && $stable(walkVpn))); // R3

  AST_NO_RSP_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    walkReq |-> !rspValid); // R3

  AST_BUSY_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    walkReq |-> !reqReady); // R10

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspCause != 2'd0) |-> (rspPaddr == '0)); // R4

  AST_QUIET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !rspValid |-> (rspCause == 2'd0)); // R2

  AST_FILL_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (walkReq && fillValid) |=> !walkReq); // R3

endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .PA_W(PFN_W + OFF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reqReady  (reqReady),
  .rspValid  (rspValid),
  .rspPaddr  (rspPaddr),
  .rspCause  (rspCause),
  .walkReq   (walkReq),
  .walkVpn   (walkVpn),
  .fillValid (fillValid)
);

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [19:0] reqVpn = '0;
  logic [11:0] reqOff = '0;
  logic        reqWrite = 1'b0, reqUser = 1'b0;
  logic        rspValid;
  logic [31:0] rspPaddr;
  logic [1:0]  rspCause;
  logic        walkReq;
  logic [19:0] walkVpn;
  logic        fillValid = 1'b0;
  logic [19:0] fillPfn = '0;
  logic        fillPresent = 1'b0, fillWritable = 1'b0, fillUser = 1'b0, fillGlobal = 1'b0;
  logic        flushTask = 1'b0;
  logic        invValid = 1'b0;
  logic [19:0] invVpn = '0;

  always #2 clk = ~clk;

  xlat_cache u_xlat_cache (.*);

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model
  bit          mV [16][4];
  logic [15:0] mT [16][4];
  int          mRr [16];

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // page table content as a function of the page number
  function automatic logic [23:0] pteOf(logic [19:0] v);
    logic [19:0] pfn;
    logic p, rw, us, g;
    pfn = v ^ 20'hA5C3F;
    p   = !(v[10] && v[11]);
    rw  = v[8];
    us  = v[9];
    g   = v[12];
    return {pfn, g, us, rw, p};
  endfunction

  function automatic logic [1:0] causeOf(logic [3:0] fl, bit wr, bit usr);
    if (!fl[0])              return 2'd1; // R4
    else if (usr && !fl[2])  return 2'd3; // R5
    else if (wr && !fl[1])   return 2'd2; // R6
    return 2'd0;
  endfunction

  task automatic access(logic [19:0] vpn, logic [11:0] off, bit wr, bit usr, string rq);
    int s, way, v;
    bit expMiss, walked, got;
    logic [23:0] e;
    logic [1:0] expCause;
    logic [31:0] expPa;
    s = int'(vpn[3:0]);
    way = -1;
    for (int w = 0; w < 4; w++) if (mV[s][w] && mT[s][w] == vpn[19:4]) way = w;
    expMiss = (way < 0);
    if (expMiss) begin
      v = -1;
      for (int w = 3; w >= 0; w--) if (!mV[s][w]) v = w;
      if (v < 0) begin v = mRr[s]; mRr[s] = (mRr[s] + 1) % 4; end
      mV[s][v] = 1'b1;
      mT[s][v] = vpn[19:4];
    end
    e = pteOf(vpn);
    expCause = causeOf(e[3:0], wr, usr);
    expPa = (expCause == 2'd0) ? {e[23:4], off} : 32'd0;

    reqValid = 1'b1; reqVpn = vpn; reqOff = off; reqWrite = wr; reqUser = usr;
    @(negedge clk);
    reqValid = 1'b0;
    walked = 0; got = 0;
    for (int i = 0; i < 12 && !got; i++) begin
      if (rspValid) got = 1;
      else if (walkReq) begin
        walked = 1;
        chk(reqReady == 1'b0, "R10", "ready during walk", reqReady, 0);
        chk(walkVpn == vpn, "R3", "walkVpn", walkVpn, vpn);
        fillValid = 1'b1; fillPfn = e[23:4];
        fillGlobal = e[3]; fillUser = e[2]; fillWritable = e[1]; fillPresent = e[0];
        reqValid = 1'b1; reqVpn = ~vpn; reqWrite = ~wr; // stray request, must be refused
        @(negedge clk);
        fillValid = 1'b0; reqValid = 1'b0;
      end else @(negedge clk);
    end
    chk(got, "R3", "response seen", got, 1);
    chk(walked == expMiss, "R3", "walk taken", walked, expMiss);
    chk(rspCause == expCause, rq, "cause", rspCause, expCause);
    chk(rspPaddr == expPa, rq, "paddr", rspPaddr, expPa);
    @(negedge clk);
    chk(rspValid == 1'b0, "R10", "single response", rspValid, 0);
  endtask

  task automatic flush();
    flushTask = 1'b1;
    @(negedge clk);
    flushTask = 1'b0;
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) begin
        logic [23:0] e;
        e = pteOf({mT[s][w], 4'(s)});
        if (!e[3]) mV[s][w] = 1'b0;
      end
  endtask

  task automatic inval(logic [19:0] vpn);
    int s;
    invValid = 1'b1; invVpn = vpn;
    @(negedge clk);
    invValid = 1'b0;
    s = int'(vpn[3:0]);
    for (int w = 0; w < 4; w++) if (mT[s][w] == vpn[19:4]) mV[s][w] = 1'b0;
  endtask

  function automatic logic [19:0] randVpn();
    logic [15:0] tg;
    logic [3:0] st;
    tg = {7'd0, ($urandom_range(0, 4) == 0), 4'($urandom_range(0, 15)), 4'd0};
    st = 4'($urandom_range(0, 3));
    return {tg, st};
  endfunction

  initial begin
    for (int s = 0; s < 16; s++) begin
      mRr[s] = 0;
      for (int w = 0; w < 4; w++) begin mV[s][w] = 1'b0; mT[s][w] = '0; end
    end
    void'($urandom(32'd7031));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "reqReady", reqReady, 1);
    chk(walkReq == 1'b0, "R1", "walkReq", walkReq, 0);
    chk(rspValid == 1'b0, "R1", "rspValid", rspValid, 0);

    // R9: overfill set 5, free ways first then round-robin
    for (int k = 0; k < 4; k++) access({16'(k) << 4, 4'd5}, 12'h123, 0, 0, "R9");
    for (int k = 0; k < 4; k++) access({16'(k) << 4, 4'd5}, 12'h456, 0, 0, "R9");
    access({16'h0040, 4'd5}, 12'h001, 0, 0, "R9");
    access({16'h0000, 4'd5}, 12'h002, 0, 0, "R9");
    access({16'h0030, 4'd5}, 12'h003, 0, 0, "R9");

    // R2: plain hit with writable user page
    access(20'h00302, 12'hABC, 1, 1, "R2");
    access(20'h00302, 12'h0FF, 0, 1, "R2");
    // R4: absent page faults on read and write
    access(20'h00C03, 12'h010, 0, 0, "R4");
    access(20'h00C03, 12'h010, 1, 0, "R4");
    chk(causeOf(pteOf(20'h00C03), 1, 1) == 2'd1, "R4", "absent ranks first", 0, 0);
    // R5: supervisor page from user mode
    access(20'h00104, 12'h020, 0, 1, "R5");
    access(20'h00104, 12'h020, 0, 0, "R5");
    // R6: read-only page written, user and write both wrong gives user
    access(20'h00206, 12'h030, 1, 1, "R6");
    access(20'h00206, 12'h030, 0, 1, "R6");
    access(20'h00006, 12'h040, 1, 1, "R6");

    // R7: flush keeps global entries
    access(20'h01307, 12'h050, 0, 0, "R7");
    access(20'h00307, 12'h060, 0, 0, "R7");
    flush();
    access(20'h01307, 12'h070, 0, 0, "R7");
    access(20'h00307, 12'h080, 0, 0, "R7");
    // R8: invalidate removes even a global entry
    inval(20'h01307);
    access(20'h01307, 12'h090, 0, 0, "R8");

    // random traffic
    for (int n = 0; n < 500; n++) begin
      int r;
      r = $urandom_range(0, 19);
      if (r < 17) access(randVpn(), 12'($urandom), 1'($urandom), 1'($urandom), "R2");
      else if (r == 17) flush();
      else inval(randVpn());
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule